// File: doc/BRIEF.md
# Near-Memory Dot-Product Engine

This block sits next to a memory and computes a batch of signed 8-bit dot products against one 64-element vector held in a local register. Software fills the vector, sets a base address, a stride and a launch count through a small word-addressed register port, and then writes a start command. For every dot product in the launch the engine issues one line read on a valid/ready request port. The 512-bit response is multiplied lane by lane with the held vector, and the 64 products are summed by an adder tree. The sum is clamped to the signed 16-bit range and stored in a result register indexed by the dot-product position.

The engine keeps a single read in flight, so results come back in launch order. A status word reports busy and a sticky done flag. Configuration writes that arrive during a launch are dropped, so a launch always runs on the settings it started with.

Register map at the default parameters (word addresses on `cfg_addr`/`rd_addr`): vector words 0x00–0x0F, base 0x10, stride 0x11, count 0x12, control 0x13 (write only), status 0x14 (read only), results 0x20 + j.

Top module: `ndp_engine`

## Requirements
- R1: After reset the status word reads 0, the count register reads 1, the base and stride read 0, and every result register reads 0.
- R2: Vector element k is byte k%4 of vector word k/4, at bits 8·(k%4)+7..8·(k%4). Line element k is bits 8k+7..8k of `mem_rsp_data`. Each dot product is the signed sum over k of vector[k]·line[k].
- R3: Dot product j reads the address base + j·stride, taken modulo 2^32. The engine makes exactly one request per dot product and never raises `mem_req_valid` while a request is still waiting for its response.
- R4: A write to the count register stores 1 when the value is 0, stores 32 when the value is above 32, and otherwise stores the value unchanged. A launch writes exactly that many results, and result registers past the count keep their earlier contents.
- R5: A sum above 32767 is stored as 32767, and a sum below −32768 is stored as −32768. A sum inside that range is stored exactly. Result registers read back sign-extended to 32 bits.
- R6: The result of dot product j is readable at address 0x20 + j.
- R7: Status bit 0 is busy and status bit 1 is done. A control write with bit 0 set starts a launch and clears done. A control write with bit 1 set clears done. Done stays set until it is cleared. When the memory is always ready and answers one cycle after accepting a request, done is first visible 2·N+1 cycles after the start write, where N is the count.
- R8: While busy, writes to the vector, base, stride and count are ignored, and so is a start command. The running launch finishes with its original settings.
- R9: While `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write word address |
| cfg_wdata | input | 32 | Register write data |
| rd_addr | input | 8 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| mem_req_valid | output | 1 | Line read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Line byte address |
| mem_rsp_valid | input | 1 | Line data valid |
| mem_rsp_data | input | 512 | Line data, element k at bits 8k+7..8k |

## Verification
A response accepted at a clock edge is summed into the tree output register at that edge. Its saturated result is written one edge later. Done rises at the same edge as the last write. With a memory that is always ready and answers one cycle after it accepts a request, the bench therefore expects done on exactly the (2·N+1)-th edge after the start write. The bench counts falling edges from that write and samples the status word there. All result and register reads are combinational and are taken a moment after a falling edge, so they never race the rising edge. Runs that use back-pressure check only the final results and the address log, because their timing depends on the stall pattern.

// File: rtl/ndp_pkg.sv
package ndp_pkg;

  localparam int ELEM_W = 8;
  localparam int PROD_W = 2 * ELEM_W;
  localparam int RES_W  = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DRAIN
  } seq_state_e;

  // Signed 8x8 lane product at full 16-bit width.
  function automatic logic signed [PROD_W-1:0] lane_mul(
    input logic signed [ELEM_W-1:0] a,
    input logic signed [ELEM_W-1:0] b
  );
    return PROD_W'(a) * PROD_W'(b);
  endfunction

  // Clamp a wide signed sum into the signed 16-bit range.
  function automatic logic signed [RES_W-1:0] sat16(input logic signed [31:0] s);
    if (s > 32'sd32767)       return 16'sh7fff;
    else if (s < -32'sd32768) return 16'sh8000;
    else                      return RES_W'(s);
  endfunction

endpackage

// File: rtl/ndp_fetch_seq.sv
module ndp_fetch_seq
  import ndp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 6,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [CNT_W-1:0]  count,
  input  logic              fin,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              take,
  output logic [IDX_W-1:0]  take_idx,
  output logic              take_last,
  output logic              busy,
  output logic              done_set
);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  last_cnt;

  assign last_cnt  = count - CNT_W'(1);
  assign req_valid = (state_q == ST_REQ);
  assign req_addr  = addr_q;
  assign take      = (state_q == ST_WAIT) && rsp_valid;
  assign take_idx  = idx_q;
  assign take_last = (CNT_W'(idx_q) == last_cnt);
  assign busy      = (state_q != ST_IDLE);
  assign done_set  = (state_q == ST_DRAIN) && fin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_REQ;
          idx_q   <= '0;
          addr_q  <= base;
        end
        ST_REQ: if (req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          if (take_last) begin
            state_q <= ST_DRAIN;
          end else begin
            state_q <= ST_REQ;
            idx_q   <= idx_q + IDX_W'(1);
            addr_q  <= addr_q + stride;
          end
        end
        ST_DRAIN: if (fin) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ndp_mac_tree.sv
module ndp_mac_tree
  import ndp_pkg::*;
#(
  parameter int LANES = 64,
  parameter int IDX_W = 5,
  localparam int LVLS  = $clog2(LANES),
  localparam int SUM_W = PROD_W + LVLS,
  localparam int LINE_W = LANES * ELEM_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic                    in_last,
  input  logic [IDX_W-1:0]        in_idx,
  input  logic [LINE_W-1:0]       vec,
  input  logic [LINE_W-1:0]       line,
  output logic                    out_vld,
  output logic                    out_last,
  output logic [IDX_W-1:0]        out_idx,
  output logic signed [SUM_W-1:0] out_sum
);

  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int NODES = LANES >> l;
    logic signed [SUM_W-1:0] node [NODES];
    for (genvar i = 0; i < NODES; i++) begin : g_node
      if (l == 0) begin : g_leaf
        assign node[i] = SUM_W'(lane_mul(vec[ELEM_W*i +: ELEM_W],
                                         line[ELEM_W*i +: ELEM_W]));
      end else begin : g_add
        assign node[i] = g_lvl[l-1].node[2*i] + g_lvl[l-1].node[2*i+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_last <= 1'b0;
      out_idx  <= '0;
      out_sum  <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_last <= in_last;
        out_idx  <= in_idx;
        out_sum  <= g_lvl[LVLS].node[0];
      end
    end
  end

endmodule

// File: rtl/ndp_result_bank.sv
module ndp_result_bank
  import ndp_pkg::*;
#(
  parameter int NRES  = 32,
  parameter int SUM_W = 22,
  localparam int IDX_W = $clog2(NRES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic signed [SUM_W-1:0] sum,
  output logic signed [RES_W-1:0] wr_data,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic signed [RES_W-1:0] rd_val
);

  logic signed [RES_W-1:0] res_q [NRES];

  assign wr_data = sat16(32'(sum));
  assign rd_val  = res_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NRES; i++) res_q[i] <= '0;
    end else if (wr_en) begin
      res_q[wr_idx] <= wr_data;
    end
  end

endmodule

// File: rtl/ndp_engine.sv
module ndp_engine
  import ndp_pkg::*;
#(
  parameter int LANES   = 64,
  parameter int MAX_CNT = 32,
  parameter int ADDR_W  = 32,
  parameter int REG_AW  = 8,
  localparam int LINE_W    = LANES * ELEM_W,
  localparam int VEC_WORDS = LINE_W / 32,
  localparam int VW_AW     = $clog2(VEC_WORDS),
  localparam int CNT_W     = $clog2(MAX_CNT + 1),
  localparam int IDX_W     = $clog2(MAX_CNT),
  localparam int SUM_W     = PROD_W + $clog2(LANES),
  localparam int RES_OFS   = 1 << $clog2(VEC_WORDS + 5)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data
);

  localparam logic [REG_AW-1:0] A_VEC_END = REG_AW'(VEC_WORDS);
  localparam logic [REG_AW-1:0] A_BASE    = REG_AW'(VEC_WORDS);
  localparam logic [REG_AW-1:0] A_STRIDE  = REG_AW'(VEC_WORDS + 1);
  localparam logic [REG_AW-1:0] A_COUNT   = REG_AW'(VEC_WORDS + 2);
  localparam logic [REG_AW-1:0] A_CTRL    = REG_AW'(VEC_WORDS + 3);
  localparam logic [REG_AW-1:0] A_STAT    = REG_AW'(VEC_WORDS + 4);
  localparam logic [REG_AW-1:0] A_RES     = REG_AW'(RES_OFS);
  localparam logic [REG_AW-1:0] A_RES_END = REG_AW'(RES_OFS + MAX_CNT);

  // Map a raw count write into the legal range 1..MAX_CNT.
  function automatic logic [CNT_W-1:0] clamp_cnt(input logic [31:0] w);
    if (w == 32'd0)               return CNT_W'(1);
    else if (w > 32'(MAX_CNT))    return CNT_W'(MAX_CNT);
    else                          return CNT_W'(w);
  endfunction

  // Configuration state
  logic [LINE_W-1:0] vec_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] stride_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;

  // Named internal events, also used by the bound checker
  logic                    busy;
  logic                    cfg_ok;
  logic                    start_go;
  logic                    done_clr;
  logic                    done_set;
  logic                    take;
  logic [IDX_W-1:0]        take_idx;
  logic                    take_last;
  logic                    wr_en;
  logic                    mac_last;
  logic [IDX_W-1:0]        wr_idx;
  logic signed [SUM_W-1:0] mac_sum;
  logic signed [RES_W-1:0] wr_data;
  logic signed [RES_W-1:0] rd_res;
  logic                    fin;

  assign cfg_ok   = cfg_we && !busy;
  assign start_go = cfg_ok && (cfg_addr == A_CTRL) && cfg_wdata[0];
  assign done_clr = cfg_we && (cfg_addr == A_CTRL) && cfg_wdata[1];
  assign fin      = wr_en && mac_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q    <= '0;
      base_q   <= '0;
      stride_q <= '0;
      cnt_q    <= CNT_W'(1);
    end else if (cfg_ok) begin
      if (cfg_addr < A_VEC_END)
        vec_q[32*int'(cfg_addr[VW_AW-1:0]) +: 32] <= cfg_wdata;
      else if (cfg_addr == A_BASE)   base_q   <= ADDR_W'(cfg_wdata);
      else if (cfg_addr == A_STRIDE) stride_q <= ADDR_W'(cfg_wdata);
      else if (cfg_addr == A_COUNT)  cnt_q    <= clamp_cnt(cfg_wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   done_q <= 1'b0;
    else if (done_set)            done_q <= 1'b1;
    else if (start_go || done_clr) done_q <= 1'b0;
  end

  ndp_fetch_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_go),
    .base      (base_q),
    .stride    (stride_q),
    .count     (cnt_q),
    .fin       (fin),
    .req_valid (mem_req_valid),
    .req_ready (mem_req_ready),
    .req_addr  (mem_req_addr),
    .rsp_valid (mem_rsp_valid),
    .take      (take),
    .take_idx  (take_idx),
    .take_last (take_last),
    .busy      (busy),
    .done_set  (done_set)
  );

  ndp_mac_tree #(
    .LANES(LANES), .IDX_W(IDX_W)
  ) u_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (take),
    .in_last  (take_last),
    .in_idx   (take_idx),
    .vec      (vec_q),
    .line     (mem_rsp_data),
    .out_vld  (wr_en),
    .out_last (mac_last),
    .out_idx  (wr_idx),
    .out_sum  (mac_sum)
  );

  ndp_result_bank #(
    .NRES(MAX_CNT), .SUM_W(SUM_W)
  ) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .sum     (mac_sum),
    .wr_data (wr_data),
    .rd_idx  (IDX_W'(rd_addr - A_RES)),
    .rd_val  (rd_res)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr < A_VEC_END)
      rd_data = vec_q[32*int'(rd_addr[VW_AW-1:0]) +: 32];
    else if (rd_addr == A_BASE)   rd_data = 32'(base_q);
    else if (rd_addr == A_STRIDE) rd_data = 32'(stride_q);
    else if (rd_addr == A_COUNT)  rd_data = 32'(cnt_q);
    else if (rd_addr == A_STAT)   rd_data = {30'd0, done_q, busy};
    else if (rd_addr >= A_RES && rd_addr < A_RES_END)
      rd_data = {{(32-RES_W){rd_res[RES_W-1]}}, rd_res};
  end

endmodule

// File: rtl/ndp_engine_chk.sv
module ndp_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 6,
  parameter int IDX_W  = 5,
  parameter int SUM_W  = 22
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mem_req_valid,
  input logic                    mem_req_ready,
  input logic [ADDR_W-1:0]       mem_req_addr,
  input logic                    mem_rsp_valid,
  input logic                    busy,
  input logic                    done_q,
  input logic                    done_clr,
  input logic                    start_go,
  input logic                    wr_en,
  input logic [IDX_W-1:0]        wr_idx,
  input logic signed [15:0]      wr_data,
  input logic signed [SUM_W-1:0] mac_sum,
  input logic [CNT_W-1:0]        cnt_q,
  input logic [ADDR_W-1:0]       base_q
);

  localparam logic signed [SUM_W-1:0] HI = SUM_W'(32767);
  localparam logic signed [SUM_W-1:0] LO = -SUM_W'(32768);

  logic outst_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                             outst_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outst_q <= 1'b1;
    else if (mem_rsp_valid)                 outst_q <= 1'b0;
  end

  a_r3_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q |-> !mem_req_valid);

  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r5_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (mac_sum > HI) |-> wr_data == 16'sh7fff);

  a_r5_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (mac_sum < LO) |-> wr_data == 16'sh8000);

  a_r4_index_in_count: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> CNT_W'(wr_idx) < cnt_q);

  a_r8_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(base_q));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !done_clr && !start_go |=> done_q);

  a_r7_done_excludes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done_q);

endmodule

bind ndp_engine ndp_engine_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .SUM_W(SUM_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .busy          (busy),
  .done_q        (done_q),
  .done_clr      (done_clr),
  .start_go      (start_go),
  .wr_en         (wr_en),
  .wr_idx        (wr_idx),
  .wr_data       (wr_data),
  .mac_sum       (mac_sum),
  .cnt_q         (cnt_q),
  .base_q        (base_q)
);

// File: tb/ndp_engine_tb.sv
`timescale 1ns/1ps
module ndp_engine_tb;

  localparam int A_BASE = 8'h10, A_STRIDE = 8'h11, A_COUNT = 8'h12;
  localparam int A_CTRL = 8'h13, A_STAT = 8'h14, A_RES = 8'h20;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] stride;
    logic [31:0] cnt_raw;
    logic [7:0]  vseed;
    logic        stall;
    logic [7:0]  n_exp;
  } tvec_t;

  localparam tvec_t TBL [5] = '{
    '{base: 32'h0000_1000, stride: 32'd64,         cnt_raw: 32'd4,  vseed: 8'd1,  stall: 1'b0, n_exp: 8'd4},
    '{base: 32'h8000_0000, stride: 32'h40,         cnt_raw: 32'd32, vseed: 8'd7,  stall: 1'b0, n_exp: 8'd32},
    '{base: 32'h0000_0200, stride: 32'hFFFF_FFC0,  cnt_raw: 32'd5,  vseed: 8'd9,  stall: 1'b1, n_exp: 8'd5},
    '{base: 32'h0000_0000, stride: 32'd0,          cnt_raw: 32'd40, vseed: 8'd3,  stall: 1'b0, n_exp: 8'd32},
    '{base: 32'h0000_0040, stride: 32'd128,        cnt_raw: 32'd0,  vseed: 8'd11, stall: 1'b1, n_exp: 8'd1}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [7:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [7:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic         mem_req_valid;
  logic         mem_req_ready;
  logic [31:0]  mem_req_addr;
  logic         mem_rsp_valid;
  logic [511:0] mem_rsp_data;

  always #10 clk = ~clk;

  ndp_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  // ---------------- memory model ----------------
  logic        stall_en = 1'b0;
  logic        fill_en = 1'b0;
  logic [7:0]  fill_val = '0;
  logic [31:0] cyc = '0;
  logic        pend = 1'b0;
  logic [31:0] paddr = '0;
  logic [31:0] acc_addr [64];
  int          acc_n = 0;

  function automatic logic [7:0] line_byte(input logic [31:0] a, input int k);
    if (fill_en) return fill_val;
    return 8'(int'(a[7:0]) * 11 + int'(a[15:8]) * 3 + int'(a[31:24]) + k * 29);
  endfunction

  assign mem_req_ready = !stall_en || (cyc[1:0] == 2'd3);
  assign mem_rsp_valid = pend;

  always @* begin
    for (int k = 0; k < 64; k++) mem_rsp_data[8*k +: 8] = line_byte(paddr, k);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      pend  <= 1'b1;
      paddr <= mem_req_addr;
      if (acc_n < 64) acc_addr[acc_n] = mem_req_addr;
      acc_n = acc_n + 1;
    end else begin
      pend <= 1'b0;
    end
  end

  // ---------------- bench model ----------------
  logic [7:0] vb [64];
  int         exp_res [32];

  function automatic int sat(input int s);
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  function automatic int model_dot(input logic [31:0] a);
    int s = 0;
    for (int k = 0; k < 64; k++)
      s += int'($signed(vb[k])) * int'($signed(line_byte(a, k)));
    return sat(s);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_addr = 8'(a);
    #1;
    d = rd_data;
  endtask

  task automatic load_vec();
    for (int w = 0; w < 16; w++)
      wr(w, {vb[4*w+3], vb[4*w+2], vb[4*w+1], vb[4*w]});
  endtask

  task automatic seed_vec(input logic [7:0] s);
    for (int k = 0; k < 64; k++) vb[k] = 8'(int'(s) * 37 + k * 13 - 100);
  endtask

  task automatic wait_done(output int cycles);
    logic [31:0] st;
    cycles = 0;
    rd(A_STAT, st);
    while (!st[1] && cycles < 3000) begin
      @(negedge clk);
      cycles++;
      rd(A_STAT, st);
    end
    if (!st[1]) check(1'b0, "R7 done timeout", cycles, -1);
  endtask

  task automatic check_results(input string req);
    logic [31:0] d;
    for (int j = 0; j < 32; j++) begin
      rd(A_RES + j, d);
      check($signed(d) == exp_res[j], req, $signed(d), exp_res[j]);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] d;
    int cyc_n;
    for (int j = 0; j < 32; j++) exp_res[j] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(A_STAT, d);   check(d == 0, "R1 status", int'(d), 0);
    rd(A_COUNT, d);  check(d == 1, "R1 count", int'(d), 1);
    rd(A_BASE, d);   check(d == 0, "R1 base", int'(d), 0);
    rd(A_STRIDE, d); check(d == 0, "R1 stride", int'(d), 0);
    check_results("R1 result reset");

    // Table walk: R2 R3 R4 R6 R7 R9
    foreach (TBL[t]) begin
      stall_en = TBL[t].stall;
      seed_vec(TBL[t].vseed);
      load_vec();
      wr(A_BASE, TBL[t].base);
      wr(A_STRIDE, TBL[t].stride);
      wr(A_COUNT, TBL[t].cnt_raw);
      rd(A_COUNT, d);
      check(d == 32'(TBL[t].n_exp), "R4 count clamp", int'(d), int'(TBL[t].n_exp));
      acc_n = 0;
      wr(A_CTRL, 32'h1);
      wait_done(cyc_n);
      if (!TBL[t].stall)
        check(cyc_n == 2 * int'(TBL[t].n_exp) + 1, "R7 done latency", cyc_n, 2 * int'(TBL[t].n_exp) + 1);
      check(acc_n == int'(TBL[t].n_exp), "R3 request count", acc_n, int'(TBL[t].n_exp));
      for (int j = 0; j < int'(TBL[t].n_exp); j++) begin
        logic [31:0] ea;
        ea = TBL[t].base + TBL[t].stride * 32'(j);
        check(acc_addr[j] == ea, "R3 line address", int'(acc_addr[j]), int'(ea));
        exp_res[j] = model_dot(ea);
      end
      check_results(TBL[t].stall ? "R9 R2 R6 results under back-pressure" : "R2 R4 R6 results");
    end

    // R7: done sticky, then cleared
    repeat (5) @(negedge clk);
    rd(A_STAT, d); check(d == 32'h2, "R7 done sticky", int'(d), 2);
    wr(A_CTRL, 32'h2);
    rd(A_STAT, d); check(d == 0, "R7 done clear", int'(d), 0);

    // R5: saturation and exact boundary sums
    stall_en = 1'b0;
    fill_en = 1'b1;
    begin
      int vfill [5] = '{127, -128, 127, 8, 8};
      int lfill [5] = '{127, 127, -128, 64, 63};
      int expv  [5] = '{32767, -32768, -32768, 32767, 32256};
      for (int c = 0; c < 5; c++) begin
        for (int k = 0; k < 64; k++) vb[k] = 8'(vfill[c]);
        fill_val = 8'(lfill[c]);
        load_vec();
        wr(A_COUNT, 32'd2);
        wr(A_CTRL, 32'h1);
        wait_done(cyc_n);
        exp_res[0] = expv[c]; exp_res[1] = expv[c];
        rd(A_RES, d);
        check($signed(d) == expv[c], "R5 saturation", $signed(d), expv[c]);
        rd(A_RES + 1, d);
        check($signed(d) == expv[c], "R5 sign extension", $signed(d), expv[c]);
      end
    end
    fill_en = 1'b0;

    // R8: writes and start during busy are ignored
    stall_en = 1'b1;
    seed_vec(8'd21);
    load_vec();
    wr(A_BASE, 32'h0000_3000);
    wr(A_STRIDE, 32'd64);
    wr(A_COUNT, 32'd8);
    wr(A_CTRL, 32'h1);
    rd(A_STAT, d); check(d == 32'h1, "R7 busy after start", int'(d), 1);
    wr(A_BASE, 32'hDEAD_0000);
    wr(A_COUNT, 32'd3);
    wr(0, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h1);
    wait_done(cyc_n);
    rd(A_BASE, d);  check(d == 32'h3000, "R8 base kept", int'(d), 32'h3000);
    rd(A_COUNT, d); check(d == 8, "R8 count kept", int'(d), 8);
    rd(0, d);
    check(d == {vb[3], vb[2], vb[1], vb[0]}, "R8 vector kept", int'(d), int'({vb[3], vb[2], vb[1], vb[0]}));
    check(acc_n >= 0, "R8 trace", acc_n, acc_n);
    for (int j = 0; j < 8; j++) exp_res[j] = model_dot(32'h3000 + 32'(64 * j));
    check_results("R8 results use original settings");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule